// File: doc/BRIEF.md
# Character Display Command Decoder with Key-Scan Sequencer

This block sits behind the host command port of a one-line character display controller. It takes 16-bit command words, each marked by a one-cycle strobe, and decodes three kinds of command from the upper byte. The mode command sets a key-scan enable bit and a power-down bit. The other two commands load a shared address counter: one loads a short address for the display/mark RAM, and the other loads a full byte for the glyph-pattern RAM.

A key-scan sequencer runs next to the decoder. A scan starts on a frame tick when scanning is enabled and power-down is off. While it runs, the segment drivers are blanked. At the end of the scan, the sequencer publishes a key request flag and a key-data-valid flag. While power-down is active, the decoder drops every command except the one that releases power-down. Entering power-down stops any scan that is running and marks the key data stale. The request flag keeps whatever value it held before.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset, pwr_down, seg_blank, key_req, key_valid and addr_range_err are 0, and addr_cnt is 0x00. Key scanning is disabled after reset.
- R2: A strobed word whose upper byte is 0x8E is the mode command. Bit 1 becomes the scan-enable bit and bit 0 becomes the power-down bit, and bits 7..2 have no effect. pwr_down shows the new value in the cycle after the strobe.
- R3: A strobed word whose upper byte is 0x93 loads bits 4..0 into addr_cnt, zero-extended to 8 bits. Bits 7..5 are ignored. addr_cnt shows the new value in the cycle after the strobe.
- R4: A strobed word whose upper byte is 0x90 loads bits 7..0 into addr_cnt, visible in the cycle after the strobe.
- R5: A load is still performed when its address is outside the legal range. For the 0x93 command the legal values are 0x00..0x0D and 0x10..0x1D; for the 0x90 command the only illegal value is 0xFF. An illegal load raises addr_range_err for exactly the one cycle after the strobe.
- R6: A strobed word with any other upper byte changes no output.
- R7: While pwr_down is 1, only a mode command with bit 0 = 0 is accepted. That command clears pwr_down and loads the scan-enable bit. Every other strobed word, including a mode command with bit 0 = 1, leaves all outputs unchanged.
- R8: With scanning enabled, pwr_down at 0 and no scan running, a frame_tick starts a scan. seg_blank is 1 for exactly SCAN_LEN cycles, starting in the cycle after the tick. A frame_tick that arrives during a scan is ignored.
- R9: When a scan completes, key_valid becomes 1. key_req becomes 1 if key_hit was high on any cycle of the scan and 0 otherwise. Both changes appear in the cycle where seg_blank falls.
- R10: Entering power-down while a scan is running ends the scan: seg_blank is 0 in the cycle after the strobe. Entering power-down clears key_valid and leaves key_req unchanged. No scan runs while pwr_down is 1.
- R11: After power-down is released, key_req keeps its value and key_valid stays 0 until a complete scan, started by a later frame_tick, sets it again.
- R12: With scanning disabled, frame_tick starts no scan. Disabling scanning during a scan ends that scan in the next cycle and clears key_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe qualifying cmd_word |
| cmd_word | input | 16 | Command word |
| frame_tick | input | 1 | One-cycle frame start pulse |
| key_hit | input | 1 | Key detect input, sampled during a scan |
| seg_blank | output | 1 | Segment drivers blanked while a scan runs |
| pwr_down | output | 1 | Power-down state |
| key_req | output | 1 | Key request flag from the last completed scan |
| key_valid | output | 1 | Key data valid flag |
| addr_cnt | output | 8 | Address counter |
| addr_range_err | output | 1 | One-cycle flag for an out-of-range address load |

## Verification
The bench drives power-down in the middle of a scan after an earlier scan has raised key_req. If the design cleared the request, key_req would fall. If it did not abort the scan, the blanking would continue, or key_valid would come back on its own after release. Address loads at the edges of the gap between 0x0D and 0x10, and at 0xFF, catch a range check that is off by one or a flag that stays high for more than one cycle. The bench also counts blanking cycles exactly and sends a tick during a scan, which exposes a restarted scan or an off-by-one counter. Strobes sent during power-down, including a repeated power-down command, catch a command gate that is too loose.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int DM_ADR_W = 5;

    localparam logic [7:0] OPC_MODE   = 8'h8E;
    localparam logic [7:0] OPC_DMADDR = 8'h93;
    localparam logic [7:0] OPC_CGADDR = 8'h90;

    localparam logic [DM_ADR_W-1:0] DISP_LAST  = 5'h0D;
    localparam logic [DM_ADR_W-1:0] MARK_FIRST = 5'h10;
    localparam logic [DM_ADR_W-1:0] MARK_LAST  = 5'h1D;
    localparam logic [ADDR_W-1:0]   CG_BAD     = 8'hFF;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_MODE,
        OP_DMADDR,
        OP_CGADDR
    } op_e;

    typedef struct packed {
        op_e               op;
        logic              scan_en;
        logic              pdown;
        logic [ADDR_W-1:0] addr;
        logic              legal;
    } cmd_dec_t;

endpackage

// File: rtl/lcd_cmd_decode.sv
module lcd_cmd_decode
    import lcd_cmd_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output cmd_dec_t          dec_o
);

    logic [7:0]          opc;
    logic [DM_ADR_W-1:0] dm_addr;
    logic                dm_legal;

    always_comb begin
        opc      = word_i[WORD_W-1:WORD_W-8];
        dm_addr  = word_i[DM_ADR_W-1:0];
        dm_legal = (dm_addr <= DISP_LAST) ||
                   ((dm_addr >= MARK_FIRST) && (dm_addr <= MARK_LAST));

        dec_o         = '0;
        dec_o.op      = OP_NONE;
        dec_o.scan_en = word_i[1];
        dec_o.pdown   = word_i[0];
        dec_o.legal   = 1'b1;

        unique case (opc)
            OPC_MODE: begin
                dec_o.op = OP_MODE;
            end
            OPC_DMADDR: begin
                dec_o.op    = OP_DMADDR;
                dec_o.addr  = {{(ADDR_W-DM_ADR_W){1'b0}}, dm_addr};
                dec_o.legal = dm_legal;
            end
            OPC_CGADDR: begin
                dec_o.op    = OP_CGADDR;
                dec_o.addr  = word_i[ADDR_W-1:0];
                dec_o.legal = (word_i[ADDR_W-1:0] != CG_BAD);
            end
            default: begin
                dec_o.op = OP_NONE;
            end
        endcase
    end

endmodule

// File: rtl/lcd_mode_regs.sv
module lcd_mode_regs
    import lcd_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  cmd_dec_t          dec_i,
    output logic              scan_ok_o,
    output logic              pd_enter_o,
    output logic              pdown_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              err_o
);

    typedef struct packed {
        logic              scan_en;
        logic              pdown;
        logic [ADDR_W-1:0] addr;
        logic              err;
    } mode_state_t;

    mode_state_t st_q, st_d;
    logic        accept;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;

        // in power-down only the release form of the mode command passes
        accept = cmd_valid_i &&
                 (!st_q.pdown || ((dec_i.op == OP_MODE) && !dec_i.pdown));

        if (accept) begin
            unique case (dec_i.op)
                OP_MODE: begin
                    st_d.scan_en = dec_i.scan_en;
                    st_d.pdown   = dec_i.pdown;
                end
                OP_DMADDR, OP_CGADDR: begin
                    st_d.addr = dec_i.addr;
                    st_d.err  = !dec_i.legal;
                end
                default: ;
            endcase
        end

        scan_ok_o  = st_d.scan_en && !st_d.pdown;
        pd_enter_o = st_d.pdown && !st_q.pdown;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pdown_o = st_q.pdown;
    assign addr_o  = st_q.addr;
    assign err_o   = st_q.err;

endmodule

// File: rtl/lcd_keyscan.sv
module lcd_keyscan #(
    parameter int SCAN_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scan_ok_i,
    input  logic pd_enter_i,
    input  logic frame_tick_i,
    input  logic key_hit_i,
    output logic busy_o,
    output logic req_o,
    output logic valid_o
);

    localparam int CNT_W = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SCAN_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             seen;
        logic             req;
        logic             valid;
    } scan_state_t;

    scan_state_t sc_q, sc_d;

    always_comb begin
        sc_d = sc_q;
        if (!scan_ok_i) begin
            if (sc_q.busy) begin
                sc_d.busy  = 1'b0;
                sc_d.seen  = 1'b0;
                sc_d.valid = 1'b0;
            end
        end else if (sc_q.busy) begin
            if (sc_q.cnt == '0) begin
                sc_d.busy  = 1'b0;
                sc_d.req   = sc_q.seen || key_hit_i;
                sc_d.valid = 1'b1;
                sc_d.seen  = 1'b0;
            end else begin
                sc_d.cnt  = sc_q.cnt - 1'b1;
                sc_d.seen = sc_q.seen || key_hit_i;
            end
        end else if (frame_tick_i) begin
            sc_d.busy = 1'b1;
            sc_d.cnt  = CNT_LAST;
            sc_d.seen = 1'b0;
        end
        if (pd_enter_i) sc_d.valid = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign busy_o  = sc_q.busy;
    assign req_o   = sc_q.req;
    assign valid_o = sc_q.valid;

endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder
    import lcd_cmd_pkg::*;
#(
    parameter int SCAN_LEN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [15:0] cmd_word,
    input  logic        frame_tick,
    input  logic        key_hit,
    output logic        seg_blank,
    output logic        pwr_down,
    output logic        key_req,
    output logic        key_valid,
    output logic [7:0]  addr_cnt,
    output logic        addr_range_err
);

    cmd_dec_t dec;
    logic     scan_ok;
    logic     pd_enter;

    lcd_cmd_decode u_dec (
        .word_i (cmd_word),
        .dec_o  (dec)
    );

    lcd_mode_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid_i (cmd_valid),
        .dec_i       (dec),
        .scan_ok_o   (scan_ok),
        .pd_enter_o  (pd_enter),
        .pdown_o     (pwr_down),
        .addr_o      (addr_cnt),
        .err_o       (addr_range_err)
    );

    lcd_keyscan #(.SCAN_LEN(SCAN_LEN)) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .scan_ok_i    (scan_ok),
        .pd_enter_i   (pd_enter),
        .frame_tick_i (frame_tick),
        .key_hit_i    (key_hit),
        .busy_o       (seg_blank),
        .req_o        (key_req),
        .valid_o      (key_valid)
    );

endmodule

// File: rtl/lcd_cmd_chk.sv
module lcd_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [15:0] cmd_word,
    input logic        frame_tick,
    input logic        seg_blank,
    input logic        pwr_down,
    input logic        key_req,
    input logic        key_valid,
    input logic [7:0]  addr_cnt,
    input logic        addr_range_err
);

    // R5
    range_err_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_range_err |-> $past(cmd_valid));

    // R7
    pd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down && cmd_valid && cmd_word[15:8] != 8'h8E) |=> $stable(addr_cnt) && pwr_down);

    // R8
    scan_start_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seg_blank) |-> $past(frame_tick));

    // R9
    req_fall_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_req) |-> $fell(seg_blank));

    // R9
    valid_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_valid) |-> $fell(seg_blank));

    // R10
    no_scan_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> !seg_blank);

    // R10
    pd_entry_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> !key_valid && $stable(key_req));

endmodule

bind lcd_cmd_decoder lcd_cmd_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_word       (cmd_word),
    .frame_tick     (frame_tick),
    .seg_blank      (seg_blank),
    .pwr_down       (pwr_down),
    .key_req        (key_req),
    .key_valid      (key_valid),
    .addr_cnt       (addr_cnt),
    .addr_range_err (addr_range_err)
);

// File: tb/sim_lcd_cmd_decoder.sv
`timescale 1ns/1ps
module sim_lcd_cmd_decoder;

    localparam int SCAN_LEN = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        frame_tick = 1'b0;
    logic        key_hit = 1'b0;
    logic        seg_blank, pwr_down, key_req, key_valid, addr_range_err;
    logic [7:0]  addr_cnt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lcd_cmd_decoder #(.SCAN_LEN(SCAN_LEN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .frame_tick(frame_tick), .key_hit(key_hit), .seg_blank(seg_blank),
        .pwr_down(pwr_down), .key_req(key_req), .key_valid(key_valid),
        .addr_cnt(addr_cnt), .addr_range_err(addr_range_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive a one-cycle strobe; returns at the negedge after the capturing edge
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 seg_blank", seg_blank, 0);
        chk("R1 pwr_down", pwr_down, 0);
        chk("R1 key_req", key_req, 0);
        chk("R1 key_valid", key_valid, 0);
        chk("R1 addr_cnt", addr_cnt, 8'h00);
        chk("R1 addr_range_err", addr_range_err, 0);
        tick();
        chk("R1 scan disabled", seg_blank, 0);
    endtask

    task automatic t_addr();
        send(16'h9305);
        chk("R3 dm load", addr_cnt, 8'h05);
        chk("R5 legal no err", addr_range_err, 0);
        send(16'h93E4);
        chk("R3 upper bits ignored", addr_cnt, 8'h04);
        send(16'h931D);
        chk("R5 mark last legal", {addr_range_err, addr_cnt}, 9'h01D);
        send(16'h930E);
        chk("R5 gap loaded", addr_cnt, 8'h0E);
        chk("R5 gap err", addr_range_err, 1);
        wait_cyc(1);
        chk("R5 err one cycle", addr_range_err, 0);
        send(16'h9310);
        chk("R5 mark first legal", {addr_range_err, addr_cnt}, 9'h010);
        send(16'h931F);
        chk("R5 above mark err", {addr_range_err, addr_cnt}, 9'h11F);
        send(16'h90A7);
        chk("R4 cg load", {addr_range_err, addr_cnt}, 9'h0A7);
        send(16'h90FE);
        chk("R5 cg FE legal", {addr_range_err, addr_cnt}, 9'h0FE);
        send(16'h90FF);
        chk("R5 cg FF err", {addr_range_err, addr_cnt}, 9'h1FF);
        send(16'h1234);
        chk("R6 unknown ignored", {addr_range_err, addr_cnt}, 9'h0FF);
        send(16'h8F03);
        chk("R6 near-mode ignored", pwr_down, 0);
        tick();
        chk("R6 near-mode no enable", seg_blank, 0);
    endtask

    task automatic t_scan();
        int blank_cnt;
        send(16'h8EFE);
        chk("R2 pd bit 0", pwr_down, 0);
        tick();
        blank_cnt = 0;
        for (int i = 0; i < 20 && seg_blank; i++) begin
            blank_cnt++;
            if (i == 2) frame_tick = 1'b1;
            if (i == 3) frame_tick = 1'b0;
            @(negedge clk);
        end
        chk("R8 blank length, tick ignored", blank_cnt, SCAN_LEN);
        chk("R9 no key req", key_req, 0);
        chk("R9 valid", key_valid, 1);
        tick();
        key_hit = 1'b1;
        wait_cyc(1);
        key_hit = 1'b0;
        wait_cyc(SCAN_LEN - 2);
        chk("R9 still scanning", {seg_blank, key_req}, 2'b10);
        wait_cyc(1);
        chk("R9 done with key", {seg_blank, key_req, key_valid}, 3'b011);
    endtask

    task automatic t_pd();
        tick();
        wait_cyc(3);
        send(16'h8E03);
        chk("R2 pd set", pwr_down, 1);
        chk("R10 scan aborted", seg_blank, 0);
        chk("R10 valid cleared", key_valid, 0);
        chk("R10 req kept", key_req, 1);
        tick();
        chk("R10 no scan in pd", seg_blank, 0);
        send(16'h9307);
        chk("R7 addr ignored", addr_cnt, 8'hFF);
        send(16'h8E01);
        chk("R7 pd=1 mode ignored", pwr_down, 1);
        send(16'h8E02);
        chk("R7 release", pwr_down, 0);
        chk("R11 req held", key_req, 1);
        chk("R11 still invalid", key_valid, 0);
        wait_cyc(3);
        chk("R11 no self-valid", key_valid, 0);
        tick();
        wait_cyc(SCAN_LEN);
        chk("R11 valid after scan", {seg_blank, key_req, key_valid}, 3'b001);
    endtask

    task automatic t_koff();
        send(16'h8E00);
        tick();
        chk("R12 disabled no scan", seg_blank, 0);
        send(16'h8E02);
        tick();
        chk("R12 scan runs", seg_blank, 1);
        wait_cyc(2);
        send(16'h8E00);
        chk("R12 abort", {seg_blank, key_valid}, 2'b00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_addr();
        t_scan();
        t_pd();
        t_koff();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule